// File: doc/BRIEF.md
# Next Program Counter Selector

This combinational block works out the address of the instruction that follows the current one in a processor whose instructions are 32-bit words on 4-byte boundaries. Each cycle it receives the current program counter, the decoded instruction fields that can redirect the flow, the value of a register that holds a jump address, and the resolved branch decision. From these it drives the next program counter. It also exposes the sequential address, current PC plus one instruction, as a separate output for return-address use.

Four routing modes are supported, picked by a 2-bit source code. The sequential mode steps one word forward. The branch mode adds a signed word displacement to the sequential address when the branch is taken, and steps forward otherwise. The region jump mode keeps the top address bits of the current PC and fills the rest from a 26-bit word index. The register jump mode passes a full 32-bit register value through unchanged. The resolver that decides whether a branch is taken, the PC register and the instruction store are outside the block.

Top module: `npc_unit`

## Requirements
- R1: With `src_sel` = 2'b00 (sequential), `pc_next` equals `pc_now` + 4, wrapping modulo 2^32.
- R2: `pc_link` equals `pc_now` + 4 in every mode, whatever the other inputs are.
- R3: With `src_sel` = 2'b01 (branch) and `br_taken` = 1, `pc_next` equals (`pc_now` + 4) + (`br_offset` sign-extended from bit 15, times 4), modulo 2^32.
- R4: With `src_sel` = 2'b01 and `br_taken` = 0, `pc_next` equals `pc_now` + 4.
- R5: The branch offset counts whole instructions in two's complement: an offset of 3 lands 16 bytes past `pc_now`, 16'hFFFF lands on `pc_now` itself, 16'h7FFF reaches +32767 words past the sequential address and 16'h8000 reaches −32768 words before it.
- R6: With `src_sel` = 2'b10 (region jump), `pc_next` equals {`pc_now`[31:28], `jmp_index`[25:0], 2'b00}; the top four bits come from the current PC, not from the sequential address.
- R7: With `src_sel` = 2'b11 (register jump), `pc_next` equals `jr_value` bit for bit, including its two low bits.
- R8: When `pc_now` is word aligned, the two low bits of `pc_next` are zero in the sequential, branch and region jump modes.
- R9: `br_taken` has no effect on `pc_next` or `pc_link` unless `src_sel` = 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_now | input | 32 | Address of the current instruction |
| br_offset | input | 16 | Signed branch displacement in instructions |
| jmp_index | input | 26 | Word index for a region jump |
| jr_value | input | 32 | Full target from a register |
| br_taken | input | 1 | Resolved branch decision |
| src_sel | input | 2 | 00 sequential, 01 branch, 10 region jump, 11 register jump |
| pc_next | output | 32 | Address of the next instruction |
| pc_link | output | 32 | Current PC plus 4 |

## Verification
The bench aims at the places where a plausible slip changes the address: the backward offset 16'hFFFF, which a design that forgot sign extension would send 256 KiB forward, and the two extreme offsets, which a design that added the displacement to `pc_now` rather than the sequential address would miss by 4. A region jump from a PC at the end of a 256 MiB region catches a design that took the top bits from PC + 4, and a register value with nonzero low bits catches one that masked it. Sequential wrap at the top of memory and a taken flag held high in non-branch modes round out the directed cases before the random sweep.

// File: rtl/npc_pkg.sv
package npc_pkg;

    // Default geometry of the instruction address space.
    localparam int unsigned NPC_ADDR_W = 32;
    localparam int unsigned NPC_OFF_W  = 16;
    localparam int unsigned NPC_TGT_W  = 26;
    localparam int unsigned NPC_ALIGN  = 2;

    // Routing source for the next address.
    typedef enum logic [1:0] {
        SRC_SEQ    = 2'b00,
        SRC_BRANCH = 2'b01,
        SRC_REGION = 2'b10,
        SRC_REG    = 2'b11
    } npc_src_e;

endpackage

// File: rtl/npc_seq_adder.sv
// Steps an address forward by one instruction.
module npc_seq_adder #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned ALIGN  = 2
) (
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_step
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN;

    always_comb begin
        addr_step = addr_in + STEP;
    end
endmodule

// File: rtl/npc_branch_target.sv
// Adds a signed instruction count, scaled to bytes, to a base address.
module npc_branch_target #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned ALIGN  = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  disp_words,
    output logic [ADDR_W-1:0] target
);
    localparam int unsigned EXT_W = ADDR_W - OFF_W - ALIGN;

    logic [ADDR_W-1:0] disp_bytes;

    always_comb begin
        disp_bytes = {{EXT_W{disp_words[OFF_W-1]}}, disp_words, {ALIGN{1'b0}}};
        target     = base + disp_bytes;
    end
endmodule

// File: rtl/npc_jump_splice.sv
// Builds a region jump address from the current region and a word index.
module npc_jump_splice #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned TGT_W  = 26,
    parameter int unsigned ALIGN  = 2
) (
    input  logic [ADDR_W-1:0] region_src,
    input  logic [TGT_W-1:0]  word_index,
    output logic [ADDR_W-1:0] target
);
    localparam int unsigned REGION_W = ADDR_W - TGT_W - ALIGN;

    always_comb begin
        target = {region_src[ADDR_W-1 -: REGION_W], word_index, {ALIGN{1'b0}}};
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int unsigned ADDR_W = NPC_ADDR_W,
    parameter int unsigned OFF_W  = NPC_OFF_W,
    parameter int unsigned TGT_W  = NPC_TGT_W,
    parameter int unsigned ALIGN  = NPC_ALIGN
) (
    input  logic [ADDR_W-1:0] pc_now,
    input  logic [OFF_W-1:0]  br_offset,
    input  logic [TGT_W-1:0]  jmp_index,
    input  logic [ADDR_W-1:0] jr_value,
    input  logic              br_taken,
    input  logic [1:0]        src_sel,
    output logic [ADDR_W-1:0] pc_next,
    output logic [ADDR_W-1:0] pc_link
);
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] br_addr;
    logic [ADDR_W-1:0] region_addr;
    npc_src_e          src;

    npc_seq_adder #(
        .ADDR_W (ADDR_W),
        .ALIGN  (ALIGN)
    ) u_seq (
        .addr_in   (pc_now),
        .addr_step (seq_addr)
    );

    npc_branch_target #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .ALIGN  (ALIGN)
    ) u_branch (
        .base       (seq_addr),
        .disp_words (br_offset),
        .target     (br_addr)
    );

    npc_jump_splice #(
        .ADDR_W (ADDR_W),
        .TGT_W  (TGT_W),
        .ALIGN  (ALIGN)
    ) u_splice (
        .region_src (pc_now),
        .word_index (jmp_index),
        .target     (region_addr)
    );

    always_comb begin
        src = npc_src_e'(src_sel);
    end

    always_comb begin
        pc_link = seq_addr;
        unique case (src)
            SRC_SEQ:    pc_next = seq_addr;
            SRC_BRANCH: pc_next = br_taken ? br_addr : seq_addr;
            SRC_REGION: pc_next = region_addr;
            SRC_REG:    pc_next = jr_value;
            default:    pc_next = seq_addr;
        endcase
    end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 16,
    parameter int unsigned TGT_W  = 26,
    parameter int unsigned ALIGN  = 2
) (
    input logic [ADDR_W-1:0] pc_now,
    input logic [OFF_W-1:0]  br_offset,
    input logic [TGT_W-1:0]  jmp_index,
    input logic [ADDR_W-1:0] jr_value,
    input logic              br_taken,
    input logic [1:0]        src_sel,
    input logic [ADDR_W-1:0] pc_next,
    input logic [ADDR_W-1:0] pc_link
);
    localparam int unsigned REGION_W = ADDR_W - TGT_W - ALIGN;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN;

    always_comb begin
        // R2: link address sits one instruction past the current PC
        p_link_step_r2: assert (pc_link - pc_now == STEP)
            else $error("link address is not one instruction ahead");

        // R1 / R4: sequential and untaken branch fall through to the link address
        if (src_sel == 2'b00 || (src_sel == 2'b01 && !br_taken)) begin
            p_fall_through_r1: assert (pc_next == pc_link)
                else $error("fall-through address differs from link");
        end

        // R5: offset of all ones lands back on the current instruction
        if (src_sel == 2'b01 && br_taken && br_offset == {OFF_W{1'b1}}) begin
            p_self_branch_r5: assert (pc_next == pc_now)
                else $error("backward one-word branch missed current PC");
        end

        // R6: region jump keeps the region bits of the current PC
        if (src_sel == 2'b10) begin
            p_region_keep_r6: assert (pc_next[ADDR_W-1 -: REGION_W] == pc_now[ADDR_W-1 -: REGION_W]
                                      && pc_next[ALIGN +: TGT_W] == jmp_index)
                else $error("region jump address malformed");
        end

        // R7: register jump passes the value through untouched
        if (src_sel == 2'b11) begin
            p_reg_pass_r7: assert (pc_next == jr_value)
                else $error("register jump altered its value");
        end

        // R8: computed targets stay word aligned
        if (src_sel != 2'b11 && pc_now[ALIGN-1:0] == '0) begin
            p_aligned_r8: assert (pc_next[ALIGN-1:0] == '0)
                else $error("computed target lost word alignment");
        end
    end
endmodule

bind npc_unit npc_unit_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .TGT_W  (TGT_W),
    .ALIGN  (ALIGN)
) u_npc_chk (
    .pc_now    (pc_now),
    .br_offset (br_offset),
    .jmp_index (jmp_index),
    .jr_value  (jr_value),
    .br_taken  (br_taken),
    .src_sel   (src_sel),
    .pc_next   (pc_next),
    .pc_link   (pc_link)
);

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_now;
    logic [15:0] br_offset;
    logic [25:0] jmp_index;
    logic [31:0] jr_value;
    logic        br_taken;
    logic [1:0]  src_sel;
    logic [31:0] pc_next;
    logic [31:0] pc_link;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    npc_unit u_npc_unit (
        .pc_now    (pc_now),
        .br_offset (br_offset),
        .jmp_index (jmp_index),
        .jr_value  (jr_value),
        .br_taken  (br_taken),
        .src_sel   (src_sel),
        .pc_next   (pc_next),
        .pc_link   (pc_link)
    );

    function automatic logic [31:0] want_next(input logic [31:0] pc, input logic [15:0] off,
                                              input logic [25:0] idx, input logic [31:0] jr,
                                              input logic tk, input logic [1:0] sel);
        logic [31:0] fall;
        logic signed [31:0] words;
        fall  = pc + 32'd4;
        words = 32'($signed(off));
        case (sel)
            2'b00:   return fall;
            2'b01:   return tk ? fall + 32'(words * 4) : fall;
            2'b10:   return {pc[31:28], idx, 2'b00};
            default: return jr;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [31:0] pc, input logic [15:0] off,
                         input logic [25:0] idx, input logic [31:0] jr,
                         input logic tk, input logic [1:0] sel);
        @(posedge clk);
        #1;
        pc_now = pc; br_offset = off; jmp_index = idx; jr_value = jr;
        br_taken = tk; src_sel = sel;
        @(negedge clk);
        check(tag, pc_next, want_next(pc, off, idx, jr, tk, sel));
        check("R2 link", pc_link, pc + 32'd4);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        pc_now = '0; br_offset = '0; jmp_index = '0; jr_value = '0;
        br_taken = 1'b0; src_sel = 2'b00;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle inputs", pc_next, 32'h0000_0004);
        check("R2 idle inputs", pc_link, 32'h0000_0004);

        apply("R1 sequential", 32'h0040_0000, 16'h0, 26'h0, 32'h0, 1'b0, 2'b00);
        apply("R1 wrap at top", 32'hFFFF_FFFC, 16'h0, 26'h0, 32'h0, 1'b0, 2'b00);
        apply("R3 taken forward", 32'h0040_0100, 16'h0010, 26'h0, 32'h0, 1'b1, 2'b01);
        apply("R5 offset three", 32'h0040_0008, 16'h0003, 26'h0, 32'h0, 1'b1, 2'b01);
        check("R5 offset three lands", pc_next, 32'h0040_0018);
        apply("R5 offset minus one", 32'h0040_0010, 16'hFFFF, 26'h0, 32'h0, 1'b1, 2'b01);
        check("R5 self target", pc_next, 32'h0040_0010);
        apply("R5 max forward", 32'h1000_0000, 16'h7FFF, 26'h0, 32'h0, 1'b1, 2'b01);
        check("R5 max forward value", pc_next, 32'h1002_0000);
        apply("R5 max backward", 32'h1000_0000, 16'h8000, 26'h0, 32'h0, 1'b1, 2'b01);
        check("R5 max backward value", pc_next, 32'h0FFE_0004);
        apply("R4 not taken", 32'h0040_0020, 16'h8000, 26'h0, 32'h0, 1'b0, 2'b01);
        apply("R6 region corner", 32'h0FFF_FFFC, 16'h0, 26'h3FF_FFFF, 32'h0, 1'b0, 2'b10);
        check("R6 region from current PC", pc_next, 32'h0FFF_FFFC);
        apply("R6 region high", 32'hA000_1234, 16'h0, 26'h010_0001, 32'h0, 1'b0, 2'b10);
        apply("R7 unaligned value", 32'h0040_0000, 16'h0, 26'h0, 32'h1234_5677, 1'b0, 2'b11);
        apply("R9 taken in sequential", 32'h0040_0040, 16'h0100, 26'h0, 32'h0, 1'b1, 2'b00);
        apply("R9 taken in region jump", 32'h3000_0000, 16'h0100, 26'h000_0040, 32'h0, 1'b1, 2'b10);
        apply("R9 taken in register jump", 32'h3000_0000, 16'h0100, 26'h0, 32'hCAFE_0000, 1'b1, 2'b11);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] pc;
            logic [1:0]  sel;
            pc  = {$urandom()} & 32'hFFFF_FFFC;
            sel = 2'($urandom_range(0, 3));
            apply(sel == 2'b01 ? "R3 random branch" : (sel == 2'b10 ? "R6 random jump" :
                  (sel == 2'b11 ? "R7 random register" : "R1 random step")),
                  pc, 16'($urandom()), 26'($urandom()), $urandom(),
                  1'($urandom()), sel);
            if (sel != 2'b11) check("R8 alignment", {30'd0, pc_next[1:0]}, 32'd0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule